// File: doc/BRIEF.md
# Programmable Interval Timer Channel

A single 16-bit timer channel that divides a counter clock enable (`tick_i`) into one of six output waveforms on `out_o`: interrupt on terminal count, gate-triggered one-shot, rate generator, square wave, software strobe and gate-triggered strobe. Software selects the mode with a control write, then writes an initial count. The count reaches the counting element on the next tick. A status flag shows when a written count has not yet been transferred. The current count can be read at any time on `count_o`.

The gate input is sampled on each tick. In the interrupt, rate, square and software-strobe modes a low gate pauses counting. In the rate and square modes a low gate also forces the output high, and a rising edge restarts the period. In the one-shot and gate-strobe modes a rising edge starts or restarts the count.

Below, N is the loaded count, with 0 meaning 65536. d is the number of counting ticks since counting started; the tick that starts counting is d = 0.

Top module: `pit_channel`

## Requirements
- R1: A written count of 0 behaves as 65536 ticks. In mode 0 the readback goes 0, 65535, and so on, and OUT rises at d = 65536.
- R2: A count write changes neither `count_o` nor the waveform until the next tick. `null_cnt_o` is high from a control or count write until the tick that transfers the count.
- R3: In modes 0 and 1, OUT is low from the start and high once d reaches N, and stays high. Mode 0 starts at the transfer tick. Mode 1 starts at a tick where the sampled gate rises, and a later rise restarts it.
- R4: In mode 2, OUT is low exactly while d mod N equals N-1, and high otherwise.
- R5: In mode 3, OUT is high while d mod N is below (N+1)/2 and low for the rest of the period. The readback has bit 0 clear and drops by two per tick within each half.
- R6: In modes 2 and 3, a gate sampled low forces OUT high. A later sampled rising edge restarts the period at d = 0.
- R7: In modes 4 and 5, OUT is low only while d equals N, once per start. Mode 4 starts at transfer; mode 5 starts at each sampled gate rise.
- R8: A gate sampled low freezes counting and the readback in modes 0, 2, 3 and 4. Modes 1 and 5 keep counting.
- R9: A control write sets OUT low for mode code 0 and high for any other code, and halts counting until a new count is transferred. Codes 6 and 7 act as modes 2 and 3.
- R10: The readback equals (N - d) mod 65536 in modes 0, 1, 4 and 5, and N - (d mod N) in mode 2. It changes only on a tick or a control write.
- R11: After reset: mode 0, OUT low, readback 0, `null_cnt_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Counter clock enable, one pulse per count |
| gate_i | input | 1 | Gate input, sampled on ticks |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_mode_i | input | 3 | Mode code for the control write |
| cnt_we_i | input | 1 | Count write strobe |
| cnt_data_i | input | 16 | Initial count, 0 means 65536 |
| out_o | output | 1 | Channel output waveform |
| count_o | output | 16 | Current count readback |
| null_cnt_o | output | 1 | Written count not yet transferred |

## Verification
Each mode is run with the gate held high, and the output and readback are compared every tick against formulas in elapsed ticks. The square wave is tried with both an odd and an even count, which separates the longer high half from the equal split. Gate-low runs in the pausable modes separate freeze from continued counting, while gate pulses in the one-shot and strobe modes separate retrigger from one-shot behavior. A zero count and the aliased mode codes 6 and 7 cover the boundary encodings.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int unsigned CNT_W = 16;

  typedef enum logic [2:0] {
    M_INT     = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE    = 3'd2,
    M_SQUARE  = 3'd3,
    M_SWSTB   = 3'd4,
    M_HWSTB   = 3'd5
  } pit_mode_e;

  function automatic pit_mode_e decode_mode(input logic [2:0] code);
    case (code)
      3'd0:    return M_INT;
      3'd1:    return M_ONESHOT;
      3'd2:    return M_RATE;
      3'd3:    return M_SQUARE;
      3'd4:    return M_SWSTB;
      3'd5:    return M_HWSTB;
      3'd6:    return M_RATE;
      default: return M_SQUARE;
    endcase
  endfunction

  // gate low freezes the count
  function automatic logic gate_pauses(input pit_mode_e m);
    return (m == M_INT) || (m == M_RATE) || (m == M_SQUARE) || (m == M_SWSTB);
  endfunction

  // gate rise starts an armed count
  function automatic logic gate_starts(input pit_mode_e m);
    return (m == M_ONESHOT) || (m == M_HWSTB);
  endfunction

  // gate rise restarts the running period
  function automatic logic gate_restarts(input pit_mode_e m);
    return (m == M_RATE) || (m == M_SQUARE);
  endfunction
endpackage

// File: rtl/pit_gate_sense.sv
module pit_gate_sense (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic gate_i,
  output logic gate_q_o,
  output logic rise_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     gate_q_o <= 1'b0;
    else if (tick_i) gate_q_o <= gate_i;
  end

  assign rise_o = tick_i & gate_i & ~gate_q_o;
endmodule

// File: rtl/pit_load_reg.sv
module pit_load_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ctrl_we_i,
  input  logic         cnt_we_i,
  input  logic [W-1:0] cnt_data_i,
  input  logic         xfer_i,
  output logic [W-1:0] init_q_o,
  output logic         pending_o,
  output logic         null_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q_o  <= '0;
      pending_o <= 1'b0;
      null_o    <= 1'b1;
    end else begin
      if (ctrl_we_i) begin
        pending_o <= 1'b0;
        null_o    <= 1'b1;
      end else if (xfer_i) begin
        pending_o <= 1'b0;
        null_o    <= 1'b0;
      end
      // a count write in the same cycle wins over both
      if (cnt_we_i) begin
        init_q_o  <= cnt_data_i;
        pending_o <= 1'b1;
        null_o    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pit_counter.sv
module pit_counter
  import pit_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  pit_mode_e    mode_i,
  input  pit_mode_e    new_mode_i,
  input  logic         ctrl_we_i,
  input  logic         xfer_i,
  input  logic         tick_i,
  input  logic         gate_i,
  input  logic         rise_i,
  input  logic [W-1:0] init_i,
  output logic [W-1:0] cnt_o,
  output logic         run_o,
  output logic         lvl_o,
  output logic         strobe_o,
  output logic         half_o
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);

  logic         armed_q, done_q;
  logic [W-1:0] init_even;
  logic         sq_end, cnt_en;

  assign init_even = {init_i[W-1:1], 1'b0};
  // odd count: high half ends at 0, all other halves end at 2
  assign sq_end    = (half_o && init_i[0]) ? (cnt_o == '0) : (cnt_o == TWO);
  assign cnt_en    = tick_i && run_o && (gate_i || !gate_pauses(mode_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o    <= '0;
      run_o    <= 1'b0;
      armed_q  <= 1'b0;
      lvl_o    <= 1'b0;
      strobe_o <= 1'b0;
      half_o   <= 1'b1;
      done_q   <= 1'b0;
    end else if (ctrl_we_i) begin
      run_o    <= 1'b0;
      armed_q  <= 1'b0;
      strobe_o <= 1'b0;
      half_o   <= 1'b1;
      done_q   <= 1'b0;
      lvl_o    <= (new_mode_i != M_INT);
      if (new_mode_i == M_SQUARE) cnt_o[0] <= 1'b0;
    end else if (xfer_i) begin
      strobe_o <= 1'b0;
      done_q   <= 1'b0;
      half_o   <= 1'b1;
      lvl_o    <= (mode_i == M_ONESHOT);
      if (gate_starts(mode_i)) begin
        run_o   <= 1'b0;
        armed_q <= 1'b1;
        cnt_o   <= init_i;
      end else begin
        run_o   <= 1'b1;
        armed_q <= 1'b0;
        cnt_o   <= (mode_i == M_SQUARE) ? init_even : init_i;
      end
    end else if (tick_i) begin
      strobe_o <= 1'b0;
      if (rise_i && armed_q && gate_starts(mode_i)) begin
        cnt_o  <= init_i;
        run_o  <= 1'b1;
        lvl_o  <= 1'b0;
        done_q <= 1'b0;
      end else if (rise_i && run_o && gate_restarts(mode_i)) begin
        cnt_o  <= (mode_i == M_SQUARE) ? init_even : init_i;
        half_o <= 1'b1;
      end else if (cnt_en) begin
        case (mode_i)
          M_INT, M_ONESHOT: begin
            cnt_o <= cnt_o - ONE;
            if (cnt_o == ONE) lvl_o <= 1'b1;
          end
          M_RATE: cnt_o <= (cnt_o == ONE) ? init_i : cnt_o - ONE;
          M_SQUARE: begin
            if (sq_end) begin
              half_o <= ~half_o;
              cnt_o  <= init_even;
            end else begin
              cnt_o  <= cnt_o - TWO;
            end
          end
          default: begin
            cnt_o <= cnt_o - ONE;
            if (cnt_o == ONE && !done_q) begin
              strobe_o <= 1'b1;
              done_q   <= 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/pit_out_dec.sv
module pit_out_dec
  import pit_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  pit_mode_e    mode_i,
  input  logic         run_i,
  input  logic [W-1:0] cnt_i,
  input  logic         lvl_i,
  input  logic         strobe_i,
  input  logic         half_i,
  input  logic         gate_q_i,
  output logic         out_o
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    case (mode_i)
      M_INT, M_ONESHOT: out_o = lvl_i;
      M_RATE:           out_o = !gate_q_i || !(run_i && cnt_i == ONE);
      M_SQUARE:         out_o = !gate_q_i || half_i;
      default:          out_o = !strobe_i;
    endcase
  end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int unsigned CNT_W = pit_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             gate_i,
  input  logic             ctrl_we_i,
  input  logic [2:0]       ctrl_mode_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_data_i,
  output logic             out_o,
  output logic [CNT_W-1:0] count_o,
  output logic             null_cnt_o
);
  pit_mode_e        mode_q, new_mode;
  logic             gate_q, rise, pending, xfer;
  logic [CNT_W-1:0] init_q;
  logic             run, lvl, strobe, half;

  assign new_mode = decode_mode(ctrl_mode_i);
  assign xfer     = tick_i && pending && !ctrl_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= M_INT;
    else if (ctrl_we_i) mode_q <= new_mode;
  end

  pit_gate_sense u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .gate_i   (gate_i),
    .gate_q_o (gate_q),
    .rise_o   (rise)
  );

  pit_load_reg #(.W(CNT_W)) u_load (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_we_i  (ctrl_we_i),
    .cnt_we_i   (cnt_we_i),
    .cnt_data_i (cnt_data_i),
    .xfer_i     (xfer),
    .init_q_o   (init_q),
    .pending_o  (pending),
    .null_o     (null_cnt_o)
  );

  pit_counter #(.W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_q),
    .new_mode_i (new_mode),
    .ctrl_we_i  (ctrl_we_i),
    .xfer_i     (xfer),
    .tick_i     (tick_i),
    .gate_i     (gate_i),
    .rise_i     (rise),
    .init_i     (init_q),
    .cnt_o      (count_o),
    .run_o      (run),
    .lvl_o      (lvl),
    .strobe_o   (strobe),
    .half_o     (half)
  );

  pit_out_dec #(.W(CNT_W)) u_out (
    .mode_i   (mode_q),
    .run_i    (run),
    .cnt_i    (count_o),
    .lvl_i    (lvl),
    .strobe_i (strobe),
    .half_i   (half),
    .gate_q_i (gate_q),
    .out_o    (out_o)
  );
endmodule

// File: rtl/pit_channel_sva.sv
module pit_channel_sva
  import pit_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick_i,
  input logic         ctrl_we_i,
  input logic [2:0]   ctrl_mode_i,
  input logic         cnt_we_i,
  input logic         out_o,
  input logic [W-1:0] count_o,
  input logic         null_cnt_o,
  input pit_mode_e    mode_i,
  input logic         gate_q_i
);
  assert_ctrl_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> (out_o == ($past(ctrl_mode_i) != 3'd0)));

  assert_null_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> null_cnt_o);

  assert_null_clr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(null_cnt_o) |-> $past(tick_i));

  assert_sq_even_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == M_SQUARE) |-> !count_o[0]);

  assert_gate_force_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == M_RATE || mode_i == M_SQUARE) && !gate_q_i) |-> out_o);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !ctrl_we_i) |=> $stable(count_o));

  assert_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == M_INT || mode_i == M_ONESHOT) && out_o && !tick_i && !ctrl_we_i)
    |=> out_o);
endmodule

bind pit_channel pit_channel_sva #(.W(CNT_W)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .ctrl_we_i   (ctrl_we_i),
  .ctrl_mode_i (ctrl_mode_i),
  .cnt_we_i    (cnt_we_i),
  .out_o       (out_o),
  .count_o     (count_o),
  .null_cnt_o  (null_cnt_o),
  .mode_i      (mode_q),
  .gate_q_i    (gate_q)
);

// File: tb/pit_channel_test.sv
module pit_channel_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        gate_i = 1'b0;
  logic        ctrl_we_i = 1'b0;
  logic [2:0]  ctrl_mode_i = 3'd0;
  logic        cnt_we_i = 1'b0;
  logic [15:0] cnt_data_i = 16'd0;
  logic        out_o;
  logic [15:0] count_o;
  logic        null_cnt_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  pit_channel uut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .gate_i      (gate_i),
    .ctrl_we_i   (ctrl_we_i),
    .ctrl_mode_i (ctrl_mode_i),
    .cnt_we_i    (cnt_we_i),
    .cnt_data_i  (cnt_data_i),
    .out_o       (out_o),
    .count_o     (count_o),
    .null_cnt_o  (null_cnt_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic tick1(input bit g);
    gate_i = g;
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic wr_ctrl(input int m);
    ctrl_mode_i = 3'(m);
    ctrl_we_i = 1'b1;
    @(negedge clk_i);
    ctrl_we_i = 1'b0;
  endtask

  task automatic wr_cnt(input int v);
    cnt_data_i = 16'(v);
    cnt_we_i = 1'b1;
    @(negedge clk_i);
    cnt_we_i = 1'b0;
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 65536 : v;
  endfunction

  function automatic int exp_out(input int m, input int n, input int d);
    case (m)
      0, 1:    return int'(d >= n);
      2:       return int'((d % n) != n - 1);
      3:       return int'((d % n) < (n + 1) / 2);
      default: return int'(d != n);
    endcase
  endfunction

  function automatic int exp_cnt(input int m, input int n, input int d);
    int p, h, q;
    case (m)
      2: return (n - d % n) & 16'hffff;
      3: begin
        p = d % n;
        h = (n + 1) / 2;
        q = (p < h) ? p : p - h;
        return (n - 2 * q) & 16'hfffe;
      end
      default: return (n - d) & 16'hffff;
    endcase
  endfunction

  task automatic chk_at(input string tag, input int m, input int n, input int d);
    chk_eq({tag, " out"}, int'(out_o), exp_out(m, n, d));
    chk_eq({tag, " count"}, int'(count_o), exp_cnt(m, n, d));
  endtask

  task automatic t_reset();
    chk_eq("R11 reset out", int'(out_o), 0);
    chk_eq("R11 reset count", int'(count_o), 0);
    chk_eq("R11 reset null", int'(null_cnt_o), 1);
  endtask

  task automatic t_mode0();
    wr_ctrl(0);
    chk_eq("R9 mode0 idle out", int'(out_o), 0);
    wr_cnt(5);
    chk_eq("R2 null after write", int'(null_cnt_o), 1);
    idle(2);
    chk_eq("R2 count before tick", int'(count_o), 0);
    chk_eq("R2 null before tick", int'(null_cnt_o), 1);
    tick1(1);
    chk_eq("R2 null cleared", int'(null_cnt_o), 0);
    chk_at("R3 mode0 start", 0, 5, 0);
    for (int d = 1; d <= 7; d++) begin
      tick1(1);
      chk_at("R3 R10 mode0", 0, 5, d);
    end
    // R8: pause with gate low
    wr_cnt(6);
    tick1(1);
    tick1(1);
    tick1(1);
    chk_at("R8 mode0 pre-pause", 0, 6, 2);
    for (int i = 0; i < 3; i++) begin
      tick1(0);
      chk_at("R8 mode0 paused", 0, 6, 2);
    end
    for (int d = 3; d <= 6; d++) begin
      tick1(1);
      chk_at("R8 mode0 resumed", 0, 6, d);
    end
  endtask

  task automatic t_mode1();
    wr_ctrl(1);
    chk_eq("R9 mode1 idle out", int'(out_o), 1);
    wr_cnt(4);
    tick1(0);
    chk_eq("R3 mode1 armed out", int'(out_o), 1);
    chk_eq("R3 mode1 armed count", int'(count_o), 4);
    tick1(0);
    tick1(0);
    chk_eq("R3 mode1 no start out", int'(out_o), 1);
    chk_eq("R3 mode1 no start count", int'(count_o), 4);
    tick1(1);
    chk_at("R3 mode1 trigger", 1, 4, 0);
    tick1(1);
    chk_at("R3 mode1", 1, 4, 1);
    tick1(1);
    chk_at("R3 mode1", 1, 4, 2);
    tick1(0);
    chk_at("R8 mode1 gate low counts", 1, 4, 3);
    tick1(1);
    chk_at("R3 mode1 retrigger", 1, 4, 0);
    for (int d = 1; d <= 5; d++) begin
      tick1(1);
      chk_at("R3 mode1 after retrigger", 1, 4, d);
    end
  endtask

  task automatic t_mode2();
    wr_ctrl(2);
    chk_eq("R9 mode2 idle out", int'(out_o), 1);
    wr_cnt(4);
    tick1(1);
    chk_at("R4 mode2 start", 2, 4, 0);
    for (int d = 1; d <= 11; d++) begin
      tick1(1);
      chk_at("R4 R10 mode2", 2, 4, d);
    end
    tick1(0);
    chk_eq("R6 mode2 gate low out", int'(out_o), 1);
    chk_eq("R8 mode2 gate low count", int'(count_o), 1);
    tick1(0);
    chk_eq("R8 mode2 still held", int'(count_o), 1);
    tick1(1);
    chk_at("R6 mode2 restart", 2, 4, 0);
    for (int d = 1; d <= 3; d++) begin
      tick1(1);
      chk_at("R6 mode2 after restart", 2, 4, d);
    end
  endtask

  task automatic t_mode3();
    wr_ctrl(3);
    chk_eq("R9 mode3 idle out", int'(out_o), 1);
    wr_cnt(5);
    tick1(1);
    chk_at("R5 mode3 odd start", 3, 5, 0);
    for (int d = 1; d <= 14; d++) begin
      tick1(1);
      chk_at("R5 mode3 odd", 3, 5, d);
    end
    wr_cnt(6);
    tick1(1);
    chk_at("R5 mode3 even start", 3, 6, 0);
    for (int d = 1; d <= 4; d++) begin
      tick1(1);
      chk_at("R5 mode3 even", 3, 6, d);
    end
    tick1(0);
    chk_eq("R6 mode3 gate low out", int'(out_o), 1);
    chk_eq("R8 mode3 gate low count", int'(count_o), exp_cnt(3, 6, 4));
    tick1(1);
    chk_at("R6 mode3 restart", 3, 6, 0);
    for (int d = 1; d <= 7; d++) begin
      tick1(1);
      chk_at("R5 mode3 after restart", 3, 6, d);
    end
  endtask

  task automatic t_mode4();
    wr_ctrl(4);
    chk_eq("R9 mode4 idle out", int'(out_o), 1);
    wr_cnt(3);
    tick1(1);
    chk_at("R7 mode4 start", 4, 3, 0);
    for (int d = 1; d <= 6; d++) begin
      tick1(1);
      chk_at("R7 R10 mode4", 4, 3, d);
    end
  endtask

  task automatic t_mode5();
    wr_ctrl(5);
    wr_cnt(2);
    tick1(0);
    chk_eq("R7 mode5 armed out", int'(out_o), 1);
    tick1(0);
    chk_eq("R7 mode5 no start count", int'(count_o), 2);
    tick1(1);
    chk_at("R7 mode5 trigger", 5, 2, 0);
    for (int d = 1; d <= 3; d++) begin
      tick1(1);
      chk_at("R7 mode5", 5, 2, d);
    end
    tick1(0);
    chk_at("R8 mode5 gate low counts", 5, 2, 4);
    tick1(1);
    chk_at("R7 mode5 retrigger", 5, 2, 0);
    for (int d = 1; d <= 3; d++) begin
      tick1(1);
      chk_at("R7 mode5 second strobe", 5, 2, d);
    end
  endtask

  task automatic t_zero();
    wr_ctrl(0);
    wr_cnt(0);
    tick1(1);
    chk_eq("R1 zero start count", int'(count_o), 0);
    chk_eq("R1 zero start out", int'(out_o), 0);
    tick1(1);
    chk_eq("R1 zero first tick", int'(count_o), 65535);
    for (int i = 2; i <= 65535; i++) tick1(1);
    chk_at("R1 zero d=65535", 0, eff(0), 65535);
    tick1(1);
    chk_at("R1 zero d=65536", 0, eff(0), 65536);
  endtask

  task automatic t_ctrl();
    wr_ctrl(6);
    chk_eq("R9 code6 idle out", int'(out_o), 1);
    wr_cnt(3);
    tick1(1);
    for (int d = 1; d <= 5; d++) begin
      tick1(1);
      chk_at("R9 code6 as rate", 2, 3, d);
    end
    wr_ctrl(7);
    wr_cnt(4);
    tick1(1);
    for (int d = 1; d <= 4; d++) begin
      tick1(1);
      chk_at("R9 code7 as square", 3, 4, d);
    end
    wr_ctrl(0);
    wr_cnt(5);
    tick1(1);
    tick1(1);
    tick1(1);
    chk_eq("R9 pre-ctrl count", int'(count_o), 3);
    wr_ctrl(0);
    chk_eq("R9 ctrl out low", int'(out_o), 0);
    chk_eq("R2 ctrl sets null", int'(null_cnt_o), 1);
    for (int i = 0; i < 3; i++) tick1(1);
    chk_eq("R9 halted count", int'(count_o), 3);
    chk_eq("R9 halted out", int'(out_o), 0);
    wr_cnt(2);
    tick1(1);
    tick1(1);
    tick1(1);
    chk_at("R9 reloaded", 0, 2, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_mode0();
    t_mode1();
    t_mode2();
    t_mode3();
    t_mode4();
    t_mode5();
    t_zero();
    t_ctrl();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule